// File: doc/BRIEF.md
# Local interrupt countdown timer

This block is the countdown timer of one processor's local interrupt unit. Software programs an initial count, a divide code and a timer entry that holds an 8-bit vector, a mask bit and a periodic/one-shot selector. Each time the counter expires the block emits a one-cycle request together with the programmed vector. Delivery of that request to the processor core is handled elsewhere.

The time base is the `tick_en` clock-enable input. A free-running prescaler turns it into divided ticks at a rate of one per 2^k input ticks, where k comes from a three-bit divide code. A controller state machine decides what each divided tick does. Its states are `ST_IDLE` (nothing pending), `ST_ONESHOT` (a single expiry pending) and `ST_PERIODIC` (expiry on every wrap). Its transitions are LOAD (an initial-count write enters `ST_PERIODIC` or `ST_ONESHOT`, or `ST_IDLE` when the count is zero), EXPIRE (`ST_ONESHOT` to `ST_IDLE` on the divided tick that finds the count at zero), WRAP (`ST_PERIODIC` to itself, reloading the count from zero), and REARM/DISARM (a timer-entry write re-derives the state from the new mode and the remaining count).

Top module: `local_countdown_timer`

## Requirements
- R1: After reset, the timer entry reads 0x0001_0000 (only the mask bit set), and the initial count, current count and divide configuration all read 0. No request is issued.
- R2: Register addresses are: 0 timer entry, 1 initial count, 2 current count (read-only), 3 divide configuration. In the timer entry only bits 17 (periodic), 16 (mask) and 7:0 (vector) are stored, and the other bits read 0. In the divide configuration only bits 3, 1 and 0 are stored, and the other bits read 0. A write to address 2 changes nothing.
- R3: The divide value is v = {bit3, bit1, bit0} with bit 3 as the MSB. One divided tick occurs every 2^((v+1) mod 8) `tick_en` pulses, so 0b111 divides by 1, 0b000 by 2 and 0b110 by 128. The prescaler restarts from zero on an initial-count write, so the first divided tick after that write comes on the 2^((v+1) mod 8)-th `tick_en`.
- R4: In periodic mode (bit 17 = 1) with initial count N, after d divided ticks the current count is N − (d mod (N+1)), and a request is issued at every d that is a nonzero multiple of N+1.
- R5: In one-shot mode (bit 17 = 0) with N > 0, the count falls to zero and holds there. Exactly one request is issued, at d = N+1. With N = 0 no request is issued.
- R6: A periodic timer with initial count 0 never issues a request, and its count stays at 0.
- R7: While the mask bit (bit 16) is set, no request is issued, but the count keeps running. Clearing the mask lets later periodic expiries issue requests.
- R8: Writing the initial count restarts timing at the write. The current count reads the written value on the next cycle, with d = 0. The write takes priority over a divided tick in the same cycle.
- R9: A timer-entry write that selects one-shot mode re-evaluates the schedule. If the count is still nonzero, the expiry stays pending. If it is already zero, including after an expiry, nothing is pending and no request follows.
- R10: A request is a pulse on `irq_pulse` of exactly one cycle, starting the cycle after the clock edge that processes the expiring divided tick. `irq_vector` carries the entry's bits 7:0 as they were at that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | Time-base clock enable, one pulse per input tick |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | DATA_W | Register write data |
| reg_rdata | output | DATA_W | Register read data for reg_addr (combinational) |
| irq_pulse | output | 1 | One-cycle interrupt request |
| irq_vector | output | VEC_W | Vector accompanying the request |

## Verification
The bench builds the block with its default parameters: a 32-bit data path, a 32-bit count and an 8-bit vector. Because the divide code spans shifts 0 to 7, the prescaler's full divide-by-128 range is exercised with small initial counts inside a short run. With these counts the periodic wrap, the one-shot expiry at N+1, the zero-count cases and the re-evaluation on an entry write after expiry are all reached many times. A behavioural model tracks elapsed divided ticks and computes the expected count and requests from the formulas above. The bench compares against that model on every clock, using both dense and pseudo-random `tick_en` patterns.

// File: rtl/ltmr_pkg.sv
package ltmr_pkg;

    typedef enum logic [1:0] {
        ST_IDLE     = 2'd0,
        ST_ONESHOT  = 2'd1,
        ST_PERIODIC = 2'd2
    } tmr_state_e;

    localparam int ADDR_W      = 2;
    localparam int SHIFT_W     = 3;
    localparam int PRE_W       = (1 << SHIFT_W) - 1;
    localparam int BIT_PERIOD  = 17;
    localparam int BIT_MASK    = 16;

    localparam logic [ADDR_W-1:0] A_ENTRY = 2'd0;
    localparam logic [ADDR_W-1:0] A_INIT  = 2'd1;
    localparam logic [ADDR_W-1:0] A_CUR   = 2'd2;
    localparam logic [ADDR_W-1:0] A_DIV   = 2'd3;

    // Divide code {b3,b1,b0} to prescaler shift, wrapping modulo 8.
    function automatic logic [SHIFT_W-1:0] code_to_shift(input logic [SHIFT_W-1:0] code);
        return code + SHIFT_W'(1);
    endfunction

endpackage

// File: rtl/ltmr_prescaler.sv
module ltmr_prescaler
    import ltmr_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clr,
    input  logic               tick_en,
    input  logic [SHIFT_W-1:0] shift,
    output logic               div_tick
);

    logic [PRE_W-1:0] presc_q;
    logic [PRE_W-1:0] low_mask;

    // Bit i of the mask is set when it lies below the selected shift.
    for (genvar i = 0; i < PRE_W; i++) begin : g_mask
        assign low_mask[i] = (SHIFT_W'(i) < shift);
    end

    assign div_tick = tick_en && ((presc_q & low_mask) == low_mask);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            presc_q <= '0;
        end else if (clr) begin
            presc_q <= '0;
        end else if (tick_en) begin
            presc_q <= presc_q + PRE_W'(1);
        end
    end

    // R3: with a nonzero, unchanged shift, two divided ticks never come back to back.
    p_spread_ticks_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (shift != '0 && $stable(shift) && $past(div_tick)) |-> !div_tick);

endmodule

// File: rtl/ltmr_regs.sv
module ltmr_regs
    import ltmr_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int CNT_W  = 32,
    parameter int VEC_W  = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               we,
    input  logic [ADDR_W-1:0]  addr,
    input  logic [DATA_W-1:0]  wdata,
    input  logic [CNT_W-1:0]   cur_count,
    output logic [DATA_W-1:0]  rdata,
    output logic               init_wr,
    output logic               entry_wr,
    output logic               new_periodic,
    output logic [CNT_W-1:0]   load_val,
    output logic [CNT_W-1:0]   init_val,
    output logic               periodic,
    output logic               masked,
    output logic [VEC_W-1:0]   vector,
    output logic [SHIFT_W-1:0] div_code
);

    logic [CNT_W-1:0]   init_q;
    logic               per_q;
    logic               mask_q;
    logic [VEC_W-1:0]   vec_q;
    logic [SHIFT_W-1:0] div_q;

    assign init_wr      = we && (addr == A_INIT);
    assign entry_wr     = we && (addr == A_ENTRY);
    assign new_periodic = wdata[BIT_PERIOD];
    assign load_val     = wdata[CNT_W-1:0];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            init_q <= '0;
            per_q  <= 1'b0;
            mask_q <= 1'b1;
            vec_q  <= '0;
            div_q  <= '0;
        end else if (we) begin
            unique case (addr)
                A_ENTRY: begin
                    per_q  <= wdata[BIT_PERIOD];
                    mask_q <= wdata[BIT_MASK];
                    vec_q  <= wdata[VEC_W-1:0];
                end
                A_INIT:  init_q <= wdata[CNT_W-1:0];
                A_DIV:   div_q  <= {wdata[3], wdata[1], wdata[0]};
                default: ;
            endcase
        end
    end

    always_comb begin
        rdata = '0;
        unique case (addr)
            A_ENTRY: begin
                rdata[BIT_PERIOD] = per_q;
                rdata[BIT_MASK]   = mask_q;
                rdata[VEC_W-1:0]  = vec_q;
            end
            A_INIT:  rdata[CNT_W-1:0] = init_q;
            A_CUR:   rdata[CNT_W-1:0] = cur_count;
            A_DIV: begin
                rdata[3] = div_q[2];
                rdata[1] = div_q[1];
                rdata[0] = div_q[0];
            end
            default: ;
        endcase
    end

    assign init_val = init_q;
    assign periodic = per_q;
    assign masked   = mask_q;
    assign vector   = vec_q;
    assign div_code = div_q;

endmodule

// File: rtl/ltmr_counter.sv
module ltmr_counter
    import ltmr_pkg::*;
#(
    parameter int CNT_W = 32,
    parameter int VEC_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             div_tick,
    input  logic             init_wr,
    input  logic [CNT_W-1:0] load_val,
    input  logic             entry_wr,
    input  logic             new_periodic,
    input  logic [CNT_W-1:0] init_val,
    input  logic             periodic,
    input  logic             masked,
    input  logic [VEC_W-1:0] vector,
    output logic [CNT_W-1:0] cur_count,
    output logic             irq_pulse,
    output logic [VEC_W-1:0] irq_vector
);

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    tmr_state_e       st_q, st_nx;
    logic [CNT_W-1:0] cnt_q, cnt_nx;
    logic             fire;
    logic             irq_q;
    logic [VEC_W-1:0] vec_q;

    always_comb begin
        st_nx  = st_q;
        cnt_nx = cnt_q;
        fire   = 1'b0;
        if (init_wr) begin
            // LOAD
            cnt_nx = load_val;
            if (load_val == '0)  st_nx = ST_IDLE;
            else if (periodic)   st_nx = ST_PERIODIC;
            else                 st_nx = ST_ONESHOT;
        end else begin
            if (div_tick) begin
                unique case (st_q)
                    ST_IDLE: begin
                        if (cnt_q != '0) cnt_nx = cnt_q - ONE;
                    end
                    ST_ONESHOT: begin
                        if (cnt_q != '0) begin
                            cnt_nx = cnt_q - ONE;
                        end else begin
                            // EXPIRE
                            fire  = 1'b1;
                            st_nx = ST_IDLE;
                        end
                    end
                    ST_PERIODIC: begin
                        if (cnt_q != '0) begin
                            cnt_nx = cnt_q - ONE;
                        end else begin
                            // WRAP
                            cnt_nx = init_val;
                            fire   = 1'b1;
                        end
                    end
                    default: st_nx = ST_IDLE;
                endcase
            end
            if (entry_wr) begin
                // REARM / DISARM
                if (new_periodic)
                    st_nx = (init_val != '0) ? ST_PERIODIC : ST_IDLE;
                else
                    st_nx = (st_nx != ST_IDLE && cnt_nx != '0) ? ST_ONESHOT : ST_IDLE;
            end
        end
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= ST_IDLE;
            cnt_q <= '0;
        end else begin
            st_q  <= st_nx;
            cnt_q <= cnt_nx;
        end
    end

    // Outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_q <= 1'b0;
            vec_q <= '0;
        end else begin
            irq_q <= fire && !masked;
            if (fire) vec_q <= vector;
        end
    end

    assign cur_count  = cnt_q;
    assign irq_pulse  = irq_q;
    assign irq_vector = vec_q;

    // R10: a request lasts exactly one cycle.
    p_single_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        irq_pulse |=> !irq_pulse);

    // R7: no request leaves while the entry was masked.
    p_mask_blocks_r7: assert property (@(posedge clk) disable iff (!rst_n)
        irq_pulse |-> !$past(masked));

    // R5: a one-shot expiry leaves the count at zero with nothing pending.
    p_oneshot_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_pulse && $past(st_q) == ST_ONESHOT && !$past(entry_wr))
            |-> (cur_count == '0 && st_q == ST_IDLE));

    // R4: a periodic expiry reloads the initial count.
    p_periodic_reload_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_pulse && $past(st_q) == ST_PERIODIC) |-> cur_count == $past(init_val));

    // R4: the count only rises on a load or on a periodic wrap.
    p_count_monotone_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_count > $past(cur_count))
            |-> ($past(init_wr) || ($past(st_q) == ST_PERIODIC && $past(cur_count) == '0)));

endmodule

// File: rtl/local_countdown_timer.sv
module local_countdown_timer
    import ltmr_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int CNT_W  = 32,
    parameter int VEC_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    input  logic              reg_we,
    input  logic [1:0]        reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              irq_pulse,
    output logic [VEC_W-1:0]  irq_vector
);

    logic               init_wr, entry_wr, new_periodic;
    logic [CNT_W-1:0]   load_val, init_val, cur_count;
    logic               periodic, masked, div_tick;
    logic [VEC_W-1:0]   vector;
    logic [SHIFT_W-1:0] div_code, shift;

    assign shift = code_to_shift(div_code);

    ltmr_regs #(.DATA_W(DATA_W), .CNT_W(CNT_W), .VEC_W(VEC_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
        .cur_count(cur_count), .rdata(reg_rdata), .init_wr(init_wr), .entry_wr(entry_wr),
        .new_periodic(new_periodic), .load_val(load_val), .init_val(init_val),
        .periodic(periodic), .masked(masked), .vector(vector), .div_code(div_code)
    );

    ltmr_prescaler u_presc (
        .clk(clk), .rst_n(rst_n), .clr(init_wr), .tick_en(tick_en),
        .shift(shift), .div_tick(div_tick)
    );

    ltmr_counter #(.CNT_W(CNT_W), .VEC_W(VEC_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .div_tick(div_tick), .init_wr(init_wr),
        .load_val(load_val), .entry_wr(entry_wr), .new_periodic(new_periodic),
        .init_val(init_val), .periodic(periodic), .masked(masked), .vector(vector),
        .cur_count(cur_count), .irq_pulse(irq_pulse), .irq_vector(irq_vector)
    );

    // R8: an initial-count write shows up as the current count next cycle.
    p_restart_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
        init_wr |=> cur_count == $past(load_val));

endmodule

// File: tb/tb_local_countdown_timer.sv
`timescale 1ns/100ps
module tb_local_countdown_timer;

    localparam int DATA_W = 32;
    localparam int CNT_W  = 32;
    localparam int VEC_W  = 8;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic              rst_n = 1'b0;
    logic              tick_en = 1'b0;
    logic              reg_we = 1'b0;
    logic [1:0]        reg_addr = 2'd2;
    logic [DATA_W-1:0] reg_wdata = '0;
    logic [DATA_W-1:0] reg_rdata;
    logic              irq_pulse;
    logic [VEC_W-1:0]  irq_vector;

    local_countdown_timer #(.DATA_W(DATA_W), .CNT_W(CNT_W), .VEC_W(VEC_W)) dut (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .reg_we(reg_we),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .irq_pulse(irq_pulse), .irq_vector(irq_vector)
    );

    int    errors = 0;
    int    checks = 0;
    string tag = "R1";
    bit    run_cmp = 1'b0;
    int    tick_mode = 0;
    logic [15:0] lfsr = 16'hACE1;
    int    dut_pulses = 0;
    int    exp_pulses = 0;

    // Time-base stimulus: off, every cycle, or pseudo-random.
    always @(posedge clk) begin
        #1;
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        tick_en = (tick_mode == 1) || (tick_mode == 2 && lfsr[0]);
    end

    // Behavioural reference: elapsed divided ticks since the last load.
    longint      m_d = 0;
    logic [31:0] m_init = 0;
    logic [31:0] m_entry = 32'h0001_0000;
    logic [3:0]  m_div = 0;
    bit          m_armed = 0;
    int          m_t = 0;
    bit          exp_irq = 0;
    logic [7:0]  exp_vec = 0;

    function automatic longint model_count();
        if (m_entry[17]) return longint'(m_init) - (m_d % (longint'(m_init) + 1));
        if (m_d >= longint'(m_init)) return 0;
        return longint'(m_init) - m_d;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_d = 0; m_init = 0; m_entry = 32'h0001_0000; m_div = 0;
            m_armed = 0; m_t = 0; exp_irq = 0; exp_vec = 0;
        end else begin
            int s, p;
            bit divt, fire;
            s = (int'({m_div[3], m_div[1:0]}) + 1) % 8;
            p = 1 << s;
            exp_irq = 0;
            fire = 0;
            if (reg_we && reg_addr == 2'd1) begin
                m_init = reg_wdata; m_d = 0; m_t = 0; m_armed = (reg_wdata != 0);
            end else begin
                divt = tick_en && ((m_t % p) == p - 1);
                if (tick_en) m_t = (m_t + 1) % 128;
                if (divt) begin
                    m_d++;
                    if (m_entry[17]) begin
                        fire = (m_init != 0) && (m_d % (longint'(m_init) + 1) == 0);
                    end else begin
                        fire = m_armed && (m_d == longint'(m_init) + 1);
                        if (fire) m_armed = 0;
                    end
                end
                if (fire && !m_entry[16]) begin
                    exp_irq = 1; exp_vec = m_entry[7:0]; exp_pulses++;
                end
                if (reg_we && reg_addr == 2'd0) begin
                    m_entry = reg_wdata & 32'h0003_00FF;
                    if (!reg_wdata[17]) m_armed = (m_d < longint'(m_init));
                end
                if (reg_we && reg_addr == 2'd3) m_div = reg_wdata[3:0] & 4'hB;
            end
        end
    end

    // Per-clock comparison away from the active edge.
    always @(negedge clk) begin
        if (rst_n && run_cmp) begin
            checks++;
            if (irq_pulse !== exp_irq || (exp_irq && irq_vector !== exp_vec)) begin
                errors++;
                $display("FAIL %s R10 request: actual pulse=%0b vec=%h expected pulse=%0b vec=%h",
                         tag, irq_pulse, irq_vector, exp_irq, exp_vec);
            end
            if (irq_pulse === 1'b1) dut_pulses++;
            if (reg_addr == 2'd2 && !reg_we) begin
                checks++;
                if (reg_rdata !== 32'(model_count())) begin
                    errors++;
                    $display("FAIL %s count: actual=%0d expected=%0d", tag, reg_rdata, model_count());
                end
            end
        end
    end

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(posedge clk); #1;
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(posedge clk); #1;
        reg_we = 1'b0; reg_addr = 2'd2;
    endtask

    task automatic rd_chk(input logic [1:0] a, input logic [31:0] exp, input string t);
        @(posedge clk); #1;
        reg_addr = a;
        #0.5;
        checks++;
        if (reg_rdata !== exp) begin
            errors++;
            $display("FAIL %s read addr %0d: actual=%h expected=%h", t, a, reg_rdata, exp);
        end
        reg_addr = 2'd2;
    endtask

    task automatic chk(input string t, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", t, act, exp);
        end
    endtask

    task automatic run(input int mode, input int n);
        tick_mode = mode;
        repeat (n) @(posedge clk);
        tick_mode = 0;
        repeat (3) @(posedge clk);
    endtask

    task automatic zero_counts();
        repeat (2) @(posedge clk);
        dut_pulses = 0; exp_pulses = 0;
    endtask

    initial begin
        repeat (5) @(posedge clk);
        #1 rst_n = 1'b1;
        run_cmp = 1'b1;

        // R1: reset values
        tag = "R1";
        rd_chk(2'd0, 32'h0001_0000, "R1");
        rd_chk(2'd1, 32'h0, "R1");
        rd_chk(2'd2, 32'h0, "R1");
        rd_chk(2'd3, 32'h0, "R1");
        zero_counts();
        run(1, 10);
        chk("R1 pulses after reset", dut_pulses, 0);

        // R2: writable bits and the read-only count
        tag = "R2";
        wr(2'd3, 32'hFFFF_FFFF);
        rd_chk(2'd3, 32'h0000_000B, "R2");
        wr(2'd0, 32'hFFFF_FFFF);
        rd_chk(2'd0, 32'h0003_00FF, "R2");
        wr(2'd2, 32'h0000_0055);
        rd_chk(2'd2, 32'h0, "R2");
        wr(2'd1, 32'd7);
        rd_chk(2'd1, 32'd7, "R2");
        tag = "R8";
        rd_chk(2'd2, 32'd7, "R8");

        // R5: one-shot, divide by 1
        tag = "R5";
        wr(2'd0, 32'h0000_0041);
        wr(2'd1, 32'd5);
        zero_counts();
        run(1, 20);
        chk("R5 one-shot pulses", dut_pulses, 1);
        chk("R5 model pulses", exp_pulses, 1);
        wr(2'd1, 32'd0);
        zero_counts();
        run(1, 10);
        chk("R5 one-shot zero count pulses", dut_pulses, 0);

        // R4: periodic, N=3
        tag = "R4";
        wr(2'd0, 32'h0002_0022);
        zero_counts();
        wr(2'd1, 32'd3);
        run(1, 30);
        chk("R4 periodic pulses", dut_pulses, exp_pulses);
        chk("R4 periodic reached", longint'(exp_pulses >= 6), 1);

        // R6: periodic with zero count
        tag = "R6";
        wr(2'd0, 32'h0002_0050);
        wr(2'd1, 32'd0);
        zero_counts();
        run(1, 20);
        chk("R6 zero periodic pulses", dut_pulses, 0);

        // R7: masked periodic keeps counting, unmask resumes requests
        tag = "R7";
        wr(2'd0, 32'h0003_00AA);
        wr(2'd1, 32'd2);
        zero_counts();
        run(1, 20);
        chk("R7 masked pulses", dut_pulses, 0);
        wr(2'd0, 32'h0002_00AA);
        zero_counts();
        run(1, 20);
        chk("R7 unmasked pulses", longint'(dut_pulses > 0), 1);

        // R3: divide codes with a sparse time base
        tag = "R3";
        wr(2'd0, 32'h0002_0077);
        foreach (div_codes[i]) begin
            wr(2'd3, 32'(div_codes[i]));
            wr(2'd1, 32'd2);
            zero_counts();
            run(2, 2000);
            chk("R3 divided pulses match", dut_pulses, exp_pulses);
            chk("R3 divided pulses seen", longint'(exp_pulses > 0), 1);
        end

        // R8: restart mid-count under divide by 16
        tag = "R8";
        wr(2'd3, 32'h3);
        wr(2'd1, 32'd6);
        run(1, 37);
        wr(2'd1, 32'd6);
        rd_chk(2'd2, 32'd6, "R8");
        run(1, 53);
        wr(2'd3, 32'hB);
        wr(2'd1, 32'd4);
        run(1, 3);

        // R9: re-evaluation on entry write
        tag = "R9";
        wr(2'd0, 32'h0001_0033);
        wr(2'd1, 32'd4);
        zero_counts();
        run(1, 20);
        wr(2'd0, 32'h0000_0033);
        run(1, 20);
        chk("R9 expired one-shot stays silent", dut_pulses, 0);
        wr(2'd0, 32'h0001_0033);
        wr(2'd1, 32'd10);
        run(1, 3);
        wr(2'd0, 32'h0000_0033);
        zero_counts();
        run(1, 20);
        chk("R9 pending one-shot fires", dut_pulses, 1);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    logic [3:0] div_codes [4] = '{4'h0, 4'h3, 4'h8, 4'hA};

    initial begin
        #(200000 * 4);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule